// File: doc/BRIEF.md
# PFC Protection and Mode Supervisor

This block supervises a boost power-factor-correction stage from already digitized comparator flags. It decides when the power switch may be driven, and it steps the converter through its life cycle: powered off, selection of the over-voltage response, standby, soft-start, regulation, over-voltage hold and latched fault. Each fault flag passes through a qualification counter of its own, so only a condition that persists for its full window can act. A short dropout restarts that window.

At power-up the block watches a mode-select level for a stable window and stores it. The stored value decides whether a second-stage over-voltage event latches the block until the next supply collapse, or lets it restart through soft-start. A bulk-voltage-good flag sets when soft-start reaches the 95% mark and clears only on the separate lower-threshold flag, or when the supply goes away. All windows are parameters counted in system-clock cycles.

Top module: `pfc_supervisor`

## Requirements
- R1: While and after reset, with no supply present, gate_en, soft_start, fault_latched and bulk_ok are all 0.
- R2: vcc_below_off high drives gate_en low in the same cycle and puts the block in the off state at the next clock edge. bulk_ok is 0 no later than the second edge.
- R3: Each fault flag must be sampled high on a run of consecutive edges equal to its window before it acts. Any low sample restarts the count. The state changes on the edge after the count completes.
- R4: After the supply rises, switching starts with soft_start high only when the qualified brownout-high flag is present, sense_open is low and no qualified enable-low exists. Until then gate_en stays 0.
- R5: A qualified brownout-low turns the gate off and enters standby. Restart goes through soft-start once brownout-high has been qualified over its window.
- R6: A qualified sense_open enters standby. Soft-start follows on the first edge where sense_open is low and the other start conditions hold.
- R7: A qualified first-stage over-voltage holds the gate off until ovp1_release is seen. Switching then resumes without soft-start when bulk_ok is 1.
- R8: In the power-up detection phase, ovp2_mode_high must stay unchanged for MODE_BLK consecutive edges. A stored 1 selects latch mode, a stored 0 selects auto-restart.
- R9: In latch mode, a qualified second-stage over-voltage sets fault_latched and holds the gate off. This lasts, whatever the other flags do, until vcc_below_off puts the block in the off state.
- R10: In auto-restart mode, a qualified second-stage over-voltage holds the gate off until ovp2_release is seen. The block then restarts through soft-start.
- R11: When both over-voltage stages have qualified in one hold episode, the gate stays off until each stage's release flag has been seen.
- R12: A qualified enable_low puts the block in standby. Once it clears, the block restarts through soft-start.
- R13: bulk_ok sets on the edge where soft-start ends because bulk_at_95 is high. It keeps its value through faults and through bulk_at_95 dropping, and it clears when bulk_below_low is high or the block is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, enters the off state |
| vcc_above_on | input | 1 | Supply above the turn-on level |
| vcc_below_off | input | 1 | Supply below the turn-off level |
| bo_above_hi | input | 1 | Line-sense input above its upper level |
| bo_below_lo | input | 1 | Line-sense input below its lower level |
| sense_open | input | 1 | Output sense below the open-loop level |
| ovp1_trip | input | 1 | Output sense above the first over-voltage level |
| ovp1_release | input | 1 | Output sense back below the regulation reference |
| ovp2_trip | input | 1 | Second over-voltage input above its level |
| ovp2_release | input | 1 | Second over-voltage input below its release level |
| enable_low | input | 1 | Enable input pulled below its threshold |
| ovp2_mode_high | input | 1 | Mode-select level, 1 selects latch mode |
| bulk_at_95 | input | 1 | Output reached 95% of rated |
| bulk_below_low | input | 1 | Output sense below the external lower threshold |
| gate_en | output | 1 | Power switch may be driven |
| soft_start | output | 1 | Soft-start phase active |
| fault_latched | output | 1 | Latched second-stage over-voltage fault |
| bulk_ok | output | 1 | Bulk voltage good |

## Verification
A behavioural model compares all four outputs on every cycle while directed patterns exercise the main paths. Fault pulses one cycle shorter than their window are distinguished from pulses that last the full window. Over-voltage episodes are tried with the first stage alone, the second stage alone and both stages together with staggered releases, which separates the hold-and-resume path from the soft-restart path. The second stage is then tried again after power cycles with each mode level. A latched fault shows through fault_latched and gate_en after its input releases, and the auto-restart case shows through soft_start.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_DETECT  = 3'd1,
    ST_STANDBY = 3'd2,
    ST_SOFT    = 3'd3,
    ST_RUN     = 3'd4,
    ST_OVP     = 3'd5,
    ST_LATCH   = 3'd6
  } sup_state_e;

  localparam int NUM_FLT = 6;
  localparam int FI_BOHI = 0;
  localparam int FI_BOLO = 1;
  localparam int FI_OLP  = 2;
  localparam int FI_OVP1 = 3;
  localparam int FI_OVP2 = 4;
  localparam int FI_EN   = 5;

  function automatic int cnt_bits(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pfc_blanker.sv
module pfc_blanker #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  import pfc_sup_pkg::*;

  localparam int CW = cnt_bits(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!raw) cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign qual = (cnt == CW'(LIMIT));

  assert_qual_needs_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(raw));
  assert_dropout_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !qual);

endmodule

// File: rtl/pfc_mode_detect.sv
module pfc_mode_detect #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic level,
  output logic done,
  output logic latch_mode
);
  import pfc_sup_pkg::*;

  localparam int CW = cnt_bits(WINDOW);

  logic [CW-1:0] cnt;
  logic          prev;
  logic          stable;

  assign stable = (level == prev);
  assign done   = active && stable && (cnt == CW'(WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      prev       <= 1'b0;
      latch_mode <= 1'b0;
    end else begin
      prev <= level;
      if (!active || !stable) cnt <= '0;
      else if (cnt != CW'(WINDOW - 1)) cnt <= cnt + 1'b1;
      if (done) latch_mode <= level;
    end
  end

  assert_mode_only_in_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_mode) |-> $past(active));

endmodule

// File: rtl/pfc_ovp_tracker.sv
module pfc_ovp_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic track,
  input  logic enter,
  input  logic ovp1_q,
  input  logic ovp2_q,
  input  logic rel1,
  input  logic rel2,
  output logic release_ok,
  output logic saw_ovp2
);
  logic w1, w2, saw;
  logic w1_cur, w2_cur, saw_cur;
  logic w1_nxt, w2_nxt, saw_nxt;

  assign w1_cur  = track & w1;
  assign w2_cur  = track & w2;
  assign saw_cur = track & saw;

  assign w1_nxt  = ovp1_q | (w1_cur & ~rel1);
  assign w2_nxt  = ovp2_q | (w2_cur & ~rel2);
  assign saw_nxt = saw_cur | ovp2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1 <= 1'b0; w2 <= 1'b0; saw <= 1'b0;
    end else if (track || enter) begin
      w1 <= w1_nxt; w2 <= w2_nxt; saw <= saw_nxt;
    end else begin
      w1 <= 1'b0; w2 <= 1'b0; saw <= 1'b0;
    end
  end

  assign release_ok = track & ~w1_nxt & ~w2_nxt;
  assign saw_ovp2   = saw_nxt;

  assert_wait_stage2_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (track && w2 && !rel2) |-> !release_ok);

endmodule

// File: rtl/pfc_bulk_monitor.sv
module pfc_bulk_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic bulk_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bulk_ok <= 1'b0;
    else if (clr_req) bulk_ok <= 1'b0;
    else if (set_req) bulk_ok <= 1'b1;
  end
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor #(
  parameter int BO_BLK   = 2500,
  parameter int OLP_BLK  = 125,
  parameter int OVP1_BLK = 1500,
  parameter int OVP2_BLK = 1500,
  parameter int EN_BLK   = 1125,
  parameter int MODE_BLK = 2250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_above_on,
  input  logic vcc_below_off,
  input  logic bo_above_hi,
  input  logic bo_below_lo,
  input  logic sense_open,
  input  logic ovp1_trip,
  input  logic ovp1_release,
  input  logic ovp2_trip,
  input  logic ovp2_release,
  input  logic enable_low,
  input  logic ovp2_mode_high,
  input  logic bulk_at_95,
  input  logic bulk_below_low,
  output logic gate_en,
  output logic soft_start,
  output logic fault_latched,
  output logic bulk_ok
);
  import pfc_sup_pkg::*;

  function automatic int flt_limit(input int idx);
    case (idx)
      FI_BOHI, FI_BOLO: return BO_BLK;
      FI_OLP:           return OLP_BLK;
      FI_OVP1:          return OVP1_BLK;
      FI_OVP2:          return OVP2_BLK;
      default:          return EN_BLK;
    endcase
  endfunction

  logic [NUM_FLT-1:0] raw_vec;
  logic [NUM_FLT-1:0] qual_vec;

  assign raw_vec[FI_BOHI] = bo_above_hi;
  assign raw_vec[FI_BOLO] = bo_below_lo;
  assign raw_vec[FI_OLP]  = sense_open;
  assign raw_vec[FI_OVP1] = ovp1_trip;
  assign raw_vec[FI_OVP2] = ovp2_trip;
  assign raw_vec[FI_EN]   = enable_low;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_blank
    pfc_blanker #(.LIMIT(flt_limit(g))) u_blank (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_vec[g]),
      .qual (qual_vec[g])
    );
  end

  sup_state_e st, nxt;

  logic mode_done, latch_mode;
  logic ovp_release, ovp_saw2, ovp_enter;
  logic start_ok, stop_req;
  logic bulk_set, bulk_clr;

  pfc_mode_detect #(.WINDOW(MODE_BLK)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (st == ST_DETECT),
    .level     (ovp2_mode_high),
    .done      (mode_done),
    .latch_mode(latch_mode)
  );

  pfc_ovp_tracker u_ovp (
    .clk       (clk),
    .rst_n     (rst_n),
    .track     (st == ST_OVP),
    .enter     (ovp_enter),
    .ovp1_q    (qual_vec[FI_OVP1]),
    .ovp2_q    (qual_vec[FI_OVP2]),
    .rel1      (ovp1_release),
    .rel2      (ovp2_release),
    .release_ok(ovp_release),
    .saw_ovp2  (ovp_saw2)
  );

  assign start_ok = qual_vec[FI_BOHI] && !sense_open && !qual_vec[FI_EN];
  assign stop_req = qual_vec[FI_EN] || qual_vec[FI_BOLO] || qual_vec[FI_OLP];

  always_comb begin
    nxt = st;
    if (vcc_below_off) begin
      nxt = ST_OFF;
    end else begin
      case (st)
        ST_OFF:     if (vcc_above_on) nxt = ST_DETECT;
        ST_DETECT:  if (mode_done) nxt = ST_STANDBY;
        ST_STANDBY: if (start_ok) nxt = ST_SOFT;
        ST_LATCH:   nxt = ST_LATCH;
        ST_SOFT, ST_RUN, ST_OVP: begin
          if (stop_req) nxt = ST_STANDBY;
          else if (qual_vec[FI_OVP2] && latch_mode) nxt = ST_LATCH;
          else if (st != ST_OVP && (qual_vec[FI_OVP1] || qual_vec[FI_OVP2])) nxt = ST_OVP;
          else if (st == ST_OVP) begin
            if (ovp_release) nxt = (ovp_saw2 || !bulk_ok) ? ST_SOFT : ST_RUN;
          end else if (st == ST_SOFT && bulk_at_95) nxt = ST_RUN;
        end
        default:    nxt = ST_OFF;
      endcase
    end
  end

  assign ovp_enter = (st != ST_OVP) && (nxt == ST_OVP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else st <= nxt;
  end

  assign bulk_set = (st == ST_SOFT) && (nxt == ST_RUN);
  assign bulk_clr = bulk_below_low || (st == ST_OFF);

  pfc_bulk_monitor u_bulk (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(bulk_set),
    .clr_req(bulk_clr),
    .bulk_ok(bulk_ok)
  );

  assign gate_en       = ((st == ST_SOFT) || (st == ST_RUN)) && !vcc_below_off;
  assign soft_start    = (st == ST_SOFT);
  assign fault_latched = (st == ST_LATCH);

  assert_off_after_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_below_off |=> (st == ST_OFF));
  assert_latch_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(qual_vec[FI_OVP2] && latch_mode));
  assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !vcc_below_off) |=> fault_latched);
  assert_soft_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_start) |-> $past((st == ST_STANDBY) || (st == ST_OVP)));
  assert_bulk_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bulk_ok) |-> $past((st == ST_SOFT) && bulk_at_95));
  assert_bulk_fall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bulk_ok) |-> $past(bulk_below_low || (st == ST_OFF)));

endmodule

// File: tb/sim_pfc_supervisor.sv
module sim_pfc_supervisor;

  localparam int P_BO = 6, P_OLP = 3, P_OVP1 = 5, P_OVP2 = 5, P_EN = 4, P_MODE = 8;
  localparam int S_OFF = 0, S_DET = 1, S_STB = 2, S_SOFT = 3, S_RUN = 4, S_OVP = 5, S_LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_above_on = 0, vcc_below_off = 1, bo_above_hi = 0, bo_below_lo = 1;
  logic sense_open = 1, ovp1_trip = 0, ovp1_release = 1, ovp2_trip = 0, ovp2_release = 1;
  logic enable_low = 0, ovp2_mode_high = 0, bulk_at_95 = 0, bulk_below_low = 1;
  logic gate_en, soft_start, fault_latched, bulk_ok;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pfc_supervisor #(.BO_BLK(P_BO), .OLP_BLK(P_OLP), .OVP1_BLK(P_OVP1),
    .OVP2_BLK(P_OVP2), .EN_BLK(P_EN), .MODE_BLK(P_MODE)) u0 (
    .clk(clk), .rst_n(rst_n), .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
    .bo_above_hi(bo_above_hi), .bo_below_lo(bo_below_lo), .sense_open(sense_open),
    .ovp1_trip(ovp1_trip), .ovp1_release(ovp1_release), .ovp2_trip(ovp2_trip),
    .ovp2_release(ovp2_release), .enable_low(enable_low), .ovp2_mode_high(ovp2_mode_high),
    .bulk_at_95(bulk_at_95), .bulk_below_low(bulk_below_low), .gate_en(gate_en),
    .soft_start(soft_start), .fault_latched(fault_latched), .bulk_ok(bulk_ok));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st = S_OFF, m_mcnt = 0, m_mprev = 0, m_latch = 0;
  int m_w1 = 0, m_w2 = 0, m_saw = 0, m_bulk = 0;
  int m_cnt[6] = '{0, 0, 0, 0, 0, 0};
  int m_lim[6] = '{P_BO, P_BO, P_OLP, P_OVP1, P_OVP2, P_EN};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = S_OFF; m_mcnt = 0; m_mprev = 0; m_latch = 0;
      m_w1 = 0; m_w2 = 0; m_saw = 0; m_bulk = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      bit q[6];
      bit r[6];
      bit done, tr, n1, n2, ns, rel, enter;
      int nst;
      r = '{bo_above_hi, bo_below_lo, sense_open, ovp1_trip, ovp2_trip, enable_low};
      foreach (q[i]) q[i] = (m_cnt[i] >= m_lim[i]);
      done = (m_st == S_DET) && (int'(ovp2_mode_high) == m_mprev) && (m_mcnt == P_MODE - 1);
      tr = (m_st == S_OVP);
      n1 = q[3] || (tr && m_w1 != 0 && !ovp1_release);
      n2 = q[4] || (tr && m_w2 != 0 && !ovp2_release);
      ns = (tr && m_saw != 0) || q[4];
      rel = tr && !n1 && !n2;
      nst = m_st;
      if (vcc_below_off) nst = S_OFF;
      else if (m_st == S_OFF) begin if (vcc_above_on) nst = S_DET; end
      else if (m_st == S_DET) begin if (done) nst = S_STB; end
      else if (m_st == S_STB) begin if (q[0] && !sense_open && !q[5]) nst = S_SOFT; end
      else if (m_st != S_LAT) begin
        if (q[5] || q[1] || q[2]) nst = S_STB;
        else if (q[4] && m_latch != 0) nst = S_LAT;
        else if (!tr && (q[3] || q[4])) nst = S_OVP;
        else if (tr) begin if (rel) nst = (ns || m_bulk == 0) ? S_SOFT : S_RUN; end
        else if (m_st == S_SOFT && bulk_at_95) nst = S_RUN;
      end
      enter = (nst == S_OVP) && !tr;
      if (tr || enter) begin m_w1 = n1; m_w2 = n2; m_saw = ns; end
      else begin m_w1 = 0; m_w2 = 0; m_saw = 0; end
      if (bulk_below_low || m_st == S_OFF) m_bulk = 0;
      else if (m_st == S_SOFT && nst == S_RUN) m_bulk = 1;
      if (done) m_latch = ovp2_mode_high;
      if (m_st != S_DET || int'(ovp2_mode_high) != m_mprev) m_mcnt = 0;
      else if (m_mcnt != P_MODE - 1) m_mcnt++;
      m_mprev = ovp2_mode_high;
      foreach (m_cnt[i]) m_cnt[i] = r[i] ? ((m_cnt[i] < m_lim[i]) ? m_cnt[i] + 1 : m_lim[i]) : 0;
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 model gate_en", gate_en, (m_st == S_SOFT || m_st == S_RUN) && !vcc_below_off);
      chk("R4 model soft_start", soft_start, m_st == S_SOFT);
      chk("R9 model fault_latched", fault_latched, m_st == S_LAT);
      chk("R13 model bulk_ok", bulk_ok, m_bulk != 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic power_up(input logic mode);
    ovp2_mode_high = mode;
    vcc_above_on = 1; vcc_below_off = 0;
    step(25);
  endtask

  task automatic reach_run();
    bulk_below_low = 0; bulk_at_95 = 1; step(2);
    bulk_at_95 = 0; step(1);
  endtask

  initial begin
    step(3);
    chk("R1 gate after reset", gate_en, 0);
    chk("R1 soft after reset", soft_start, 0);
    chk("R1 latched after reset", fault_latched, 0);
    chk("R1 bulk after reset", bulk_ok, 0);
    rst_n = 1; step(2);
    chk("R1 bulk idle", bulk_ok, 0);

    // supply on, line still low: no switching
    vcc_above_on = 1; vcc_below_off = 0; step(30);
    chk("R4 no start without line", gate_en, 0);
    bo_above_hi = 1; bo_below_lo = 0; sense_open = 0; step(20);
    chk("R4 soft start begins", soft_start, 1);
    chk("R4 gate on", gate_en, 1);

    bulk_below_low = 0; bulk_at_95 = 1; step(2);
    chk("R13 bulk set", bulk_ok, 1);
    chk("R13 soft ends", soft_start, 0);
    bulk_at_95 = 0; step(3);
    chk("R13 bulk holds", bulk_ok, 1);

    // OVP1 glitch shorter than window
    ovp1_trip = 1; ovp1_release = 0; step(P_OVP1 - 1);
    ovp1_trip = 0; step(3);
    chk("R3 short ovp1 ignored", gate_en, 1);
    ovp1_trip = 1; step(10);
    chk("R7 ovp1 gate off", gate_en, 0);
    ovp1_trip = 0; step(5);
    chk("R7 waits for release", gate_en, 0);
    ovp1_release = 1; step(2);
    chk("R7 resumes", gate_en, 1);
    chk("R7 no soft start", soft_start, 0);

    // OVP2, auto mode
    ovp2_trip = 1; ovp2_release = 0; step(10);
    chk("R10 ovp2 gate off", gate_en, 0);
    chk("R10 not latched", fault_latched, 0);
    ovp2_trip = 0; ovp2_release = 1; step(3);
    chk("R10 soft restart", soft_start, 1);
    reach_run();

    // both stages
    ovp1_trip = 1; ovp1_release = 0; ovp2_trip = 1; ovp2_release = 0; step(10);
    ovp1_trip = 0; ovp2_trip = 0; ovp1_release = 1; step(4);
    chk("R11 waits second release", gate_en, 0);
    ovp2_release = 1; step(2);
    chk("R11 restarts", gate_en, 1);
    chk("R11 via soft start", soft_start, 1);
    reach_run();

    // enable low
    enable_low = 1; step(P_EN - 1);
    enable_low = 0; step(3);
    chk("R12 short enable low ignored", gate_en, 1);
    enable_low = 1; step(8);
    chk("R12 standby gate", gate_en, 0);
    chk("R12 standby soft", soft_start, 0);
    chk("R13 bulk kept in standby", bulk_ok, 1);
    enable_low = 0; step(8);
    chk("R12 recovery soft", soft_start, 1);
    reach_run();

    // brownout
    bo_below_lo = 1; bo_above_hi = 0; step(10);
    chk("R5 brownout gate off", gate_en, 0);
    bo_below_lo = 0; bo_above_hi = 1; step(3);
    chk("R5 restart blanked", gate_en, 0);
    step(10);
    chk("R5 soft restart", soft_start, 1);
    reach_run();

    // open loop
    sense_open = 1; step(6);
    chk("R6 open loop gate off", gate_en, 0);
    bulk_below_low = 1; step(2);
    chk("R13 bulk cleared", bulk_ok, 0);
    sense_open = 0; step(4);
    chk("R6 soft restart", soft_start, 1);

    // supply drop
    vcc_below_off = 1; vcc_above_on = 0; #1;
    chk("R2 gate drops at once", gate_en, 0);
    step(3);
    chk("R2 off soft", soft_start, 0);
    chk("R2 off bulk", bulk_ok, 0);

    // latch mode
    power_up(1);
    chk("R8 start in latch mode", soft_start, 1);
    ovp2_trip = 1; ovp2_release = 0; step(10);
    chk("R9 latched", fault_latched, 1);
    chk("R9 gate off", gate_en, 0);
    ovp2_trip = 0; ovp2_release = 1; step(10);
    chk("R9 stays latched", fault_latched, 1);
    chk("R9 gate stays off", gate_en, 0);
    vcc_below_off = 1; vcc_above_on = 0; step(3);
    chk("R9 cleared by supply cycle", fault_latched, 0);

    // back to auto mode
    power_up(0);
    ovp2_trip = 1; ovp2_release = 0; step(10);
    chk("R8 auto mode not latched", fault_latched, 0);
    chk("R8 auto gate off", gate_en, 0);
    ovp2_trip = 0; ovp2_release = 1; step(3);
    chk("R8 auto restarts", soft_start, 1);

    step(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule